// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block prepares the second operand of a 32-bit RISC-style datapath. It reads the low bits of an instruction word together with the value read from the source register and, when asked to, a second register value that holds a shift amount. It returns the shifted or rotated operand, the carry bit that the shift pushed out, and a separate write enable for a carry flag register held elsewhere.

Three encodings are accepted, chosen by a format select: the register form (a register value shifted by an immediate or register-held amount), the rotated 8-bit immediate form, and a compact form taken from a 16-bit instruction. The block is purely combinational. A caller that must not use register-held amounts or touch the flags, such as an address-offset path, clears the two control inputs that permit them.

Top module: `opsh_operand_unit`

## Requirements
- R1: In the register form (fmt_i = 00), field_i[6:5] selects the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R2: src_idx_o is field_i[3:0] in the register form and {0, field_i[5:3]} in the compact form (fmt_i = 10); dst_idx_o is field_i[2:0] in the compact form.
- R3: In the register form the shift amount is the low 8 bits of amt_reg_i when allow_reg_amt_i is 1 and field_i[4] is 1; otherwise it is field_i[11:7].
- R4: A logical left shift by n, 1 <= n <= 32, gives carry_o equal to input bit 32-n.
- R5: Logical right, arithmetic right and rotate right by n, 1 <= n <= 32, give carry_o equal to input bit n-1.
- R6: In the register form carry_we_o is 1 only when set_flags_i is 1; the shifted operand appears on operand_o whatever set_flags_i is.
- R7: A shift amount of zero passes the input to operand_o unchanged and holds carry_we_o at 0.
- R8: Logical shifts by 32 or more give 0, with carry input bit 0 (left) or bit 31 (right) at exactly 32 and 0 above it; arithmetic right by 32 or more gives 32 copies of bit 31 and carry bit 31; rotate right by a nonzero multiple of 32 leaves the value unchanged with carry bit 31.
- R9: In the immediate form (fmt_i = 01), operand_o is field_i[7:0] zero-extended and rotated right by twice field_i[11:8], and carry_we_o is always 0.
- R10: In the compact form, field_i[12:11] is the shift (00 left, 01 logical right, 10 arithmetic right), field_i[10:6] the amount, and carry_we_o is 1 whenever the amount is nonzero, regardless of set_flags_i.
- R11: Compact op 11 and fmt_i = 11 raise invalid_o and force operand_o to 0 and carry_we_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_i | input | 2 | Encoding select: 00 register, 01 rotated immediate, 10 compact, 11 reserved |
| field_i | input | 16 | Low instruction bits holding the operand field |
| reg_val_i | input | 32 | Value read from the source register |
| amt_reg_i | input | 32 | Value read from the register holding a shift amount |
| allow_reg_amt_i | input | 1 | Permits register-held shift amounts in the register form |
| set_flags_i | input | 1 | Requests a carry update in the register form |
| operand_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Carry pushed out by the shift |
| carry_we_o | output | 1 | Write enable for the carry flag |
| invalid_o | output | 1 | Encoding not supported |
| src_idx_o | output | 4 | Source register index |
| dst_idx_o | output | 3 | Destination register index in the compact form |

## Verification
The bench aims at the amount boundaries: zero, one, thirty-one, thirty-two, thirty-three and large register amounts whose upper bits must be dropped. A design that indexed the carry bit without guarding zero would raise a carry update on a pass-through, and one that masked the register amount to five bits would treat 33 as a shift by one instead of clearing the result. It also drives the flag-setting gate in each format, so that an immediate that writes carry or a compact shift that depends on set_flags_i shows up, and a rotate by 64 that a design mistook for zero would drop its carry update.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  localparam int unsigned AMT_W   = 8;
  localparam int unsigned FIELD_W = 16;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    FMT_REG    = 2'b00,
    FMT_ROTIMM = 2'b01,
    FMT_HALF   = 2'b10,
    FMT_RSVD   = 2'b11
  } op_fmt_e;

  typedef struct packed {
    shift_kind_e      kind;
    logic [AMT_W-1:0] amt;
    logic             use_imm;
    logic             flag_en;
    logic             invalid;
    logic [3:0]       src_idx;
    logic [2:0]       dst_idx;
  } shift_ctl_t;

endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]         fmt_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               allow_reg_amt_i,
  input  logic [XLEN-1:0]    amt_reg_i,
  input  logic               set_flags_i,
  output shift_ctl_t         ctl_o
);

  localparam int unsigned IMM_AMT_W = 5;
  localparam int unsigned PAD_W     = AMT_W - IMM_AMT_W;

  op_fmt_e fmt;
  logic    reg_amt_sel;

  assign fmt         = op_fmt_e'(fmt_i);
  assign reg_amt_sel = allow_reg_amt_i & field_i[4];

  always_comb begin
    ctl_o = '0;
    unique case (fmt)
      FMT_REG: begin
        ctl_o.kind    = shift_kind_e'(field_i[6:5]);
        ctl_o.amt     = reg_amt_sel ? amt_reg_i[AMT_W-1:0]
                                    : {{PAD_W{1'b0}}, field_i[11:7]};
        ctl_o.flag_en = set_flags_i;
        ctl_o.src_idx = field_i[3:0];
      end
      FMT_ROTIMM: begin
        ctl_o.kind    = SHK_ROR;
        ctl_o.amt     = {{(AMT_W-5){1'b0}}, field_i[11:8], 1'b0};
        ctl_o.use_imm = 1'b1;
      end
      FMT_HALF: begin
        ctl_o.kind    = shift_kind_e'(field_i[12:11]);
        ctl_o.amt     = {{PAD_W{1'b0}}, field_i[10:6]};
        ctl_o.invalid = (field_i[12:11] == 2'b11);
        ctl_o.flag_en = (field_i[12:11] != 2'b11);
        ctl_o.src_idx = {1'b0, field_i[5:3]};
        ctl_o.dst_idx = field_i[2:0];
      end
      default: begin
        ctl_o.invalid = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (fmt == FMT_ROTIMM)
      a_r9_imm_flags_off: assert (!ctl_o.flag_en)
        else $error("immediate form enabled flag update");
    if (fmt == FMT_REG && !allow_reg_amt_i)
      a_r3_field_amount: assert (ctl_o.amt[AMT_W-1:IMM_AMT_W] == '0)
        else $error("register amount used while disallowed");
  end

endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [XLEN-1:0]  val_i,
  output logic [XLEN-1:0]  res_o,
  output logic             cout_o,
  output logic             active_o
);

  localparam int unsigned LG = $clog2(XLEN);

  logic [2*XLEN:0]      lsl_w;
  logic [XLEN:0]        lsr_w;
  logic signed [XLEN:0] asr_w;
  logic [2*XLEN-1:0]    ror_w;
  logic [LG-1:0]        rot;

  always_comb begin
    lsl_w = {{(XLEN+1){1'b0}}, val_i} << amt_i;
    lsr_w = {val_i, 1'b0} >> amt_i;
    asr_w = $signed({val_i, 1'b0}) >>> amt_i;
    rot   = amt_i[LG-1:0];
    ror_w = {val_i, val_i} >> rot;
  end

  always_comb begin
    unique case (kind_i)
      SHK_LSL: begin res_o = lsl_w[XLEN-1:0]; cout_o = lsl_w[XLEN];   end
      SHK_LSR: begin res_o = lsr_w[XLEN:1];   cout_o = lsr_w[0];      end
      SHK_ASR: begin res_o = asr_w[XLEN:1];   cout_o = asr_w[0];      end
      default: begin res_o = ror_w[XLEN-1:0]; cout_o = ror_w[XLEN-1]; end
    endcase
  end

  assign active_o = |amt_i;

  always_comb begin
    if (!active_o)
      a_r7_zero_passthru: assert (res_o == val_i)
        else $error("zero amount altered the value");
    if (kind_i == SHK_LSR && amt_i > AMT_W'(XLEN))
      a_r8_lsr_clear: assert (res_o == '0 && !cout_o)
        else $error("long logical right shift left bits behind");
    if (kind_i == SHK_ASR && amt_i >= AMT_W'(XLEN))
      a_r8_asr_fill: assert (res_o == {XLEN{val_i[XLEN-1]}} && cout_o == val_i[XLEN-1])
        else $error("long arithmetic shift not sign filled");
  end

endmodule

// File: rtl/opsh_operand_unit.sv
module opsh_operand_unit
  import opsh_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 8
) (
  input  logic [1:0]         fmt_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [XLEN-1:0]    reg_val_i,
  input  logic [XLEN-1:0]    amt_reg_i,
  input  logic               allow_reg_amt_i,
  input  logic               set_flags_i,
  output logic [XLEN-1:0]    operand_o,
  output logic               carry_o,
  output logic               carry_we_o,
  output logic               invalid_o,
  output logic [3:0]         src_idx_o,
  output logic [2:0]         dst_idx_o
);

  shift_ctl_t      ctl;
  logic [XLEN-1:0] shift_in;
  logic [XLEN-1:0] shift_res;
  logic            shift_cout;
  logic            shift_active;

  opsh_decode #(.XLEN(XLEN)) u_decode (
    .fmt_i           (fmt_i),
    .field_i         (field_i),
    .allow_reg_amt_i (allow_reg_amt_i),
    .amt_reg_i       (amt_reg_i),
    .set_flags_i     (set_flags_i),
    .ctl_o           (ctl)
  );

  assign shift_in = ctl.use_imm ? {{(XLEN-IMM_W){1'b0}}, field_i[IMM_W-1:0]}
                                : reg_val_i;

  opsh_barrel #(.XLEN(XLEN)) u_barrel (
    .kind_i   (ctl.kind),
    .amt_i    (ctl.amt),
    .val_i    (shift_in),
    .res_o    (shift_res),
    .cout_o   (shift_cout),
    .active_o (shift_active)
  );

  assign operand_o  = ctl.invalid ? '0 : shift_res;
  assign carry_o    = shift_cout & ~ctl.invalid;
  assign carry_we_o = ctl.flag_en & shift_active & ~ctl.invalid;
  assign invalid_o  = ctl.invalid;
  assign src_idx_o  = ctl.src_idx;
  assign dst_idx_o  = ctl.dst_idx;

  always_comb begin
    if (invalid_o)
      a_r11_invalid_quiet: assert (operand_o == '0 && !carry_we_o)
        else $error("invalid encoding produced output");
    if (fmt_i == 2'b00 && !set_flags_i)
      a_r6_no_flag_request: assert (!carry_we_o)
        else $error("carry written without request");
    if (fmt_i == 2'b01)
      a_r9_imm_no_carry: assert (!carry_we_o)
        else $error("immediate form wrote carry");
  end

endmodule

// File: tb/test_opsh_operand_unit.sv
module test_opsh_operand_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt;
  logic [15:0] field;
  logic [31:0] rval, areg;
  logic        allow, sflags;
  logic [31:0] operand;
  logic        carry, carry_we, invalid;
  logic [3:0]  src_idx;
  logic [2:0]  dst_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opsh_operand_unit i_opsh_operand_unit (
    .fmt_i(fmt), .field_i(field), .reg_val_i(rval), .amt_reg_i(areg),
    .allow_reg_amt_i(allow), .set_flags_i(sflags),
    .operand_o(operand), .carry_o(carry), .carry_we_o(carry_we),
    .invalid_o(invalid), .src_idx_o(src_idx), .dst_idx_o(dst_idx)
  );

  function automatic logic [15:0] mk_reg(input int amt5, input int kind, input bit rflag, input int rm);
    return 16'((amt5 & 31) << 7 | (kind & 3) << 5 | int'(rflag) << 4 | (rm & 15));
  endfunction

  function automatic logic [15:0] mk_half(input int op, input int amt5, input int rs, input int rd);
    return 16'((op & 3) << 11 | (amt5 & 31) << 6 | (rs & 7) << 3 | (rd & 7));
  endfunction

  // Behavioural reference: one shift at a time, integer amounts.
  task automatic model(output logic [31:0] e_op, output logic e_c, output logic e_we,
                       output logic e_inv, output logic [3:0] e_src, output logic [2:0] e_dst);
    int n, kind, r;
    logic [31:0] v;
    bit fl;
    e_inv = 0; e_src = 0; e_dst = 0; fl = 0; kind = 0; n = 0; v = rval;
    case (fmt)
      2'b00: begin
        kind = int'(field[6:5]);
        n = (allow && field[4]) ? int'(areg[7:0]) : int'(field[11:7]);
        fl = sflags; e_src = field[3:0];
      end
      2'b01: begin kind = 3; n = 2 * int'(field[11:8]); v = {24'h0, field[7:0]}; end
      2'b10: begin
        kind = int'(field[12:11]); n = int'(field[10:6]);
        e_src = {1'b0, field[5:3]}; e_dst = field[2:0];
        if (kind == 3) e_inv = 1; else fl = 1;
      end
      default: e_inv = 1;
    endcase
    e_op = v; e_c = 0;
    if (n != 0) begin
      case (kind)
        0: begin e_op = (n >= 32) ? 32'h0 : v << n; e_c = (n > 32) ? 1'b0 : v[32-n]; end
        1: begin e_op = (n >= 32) ? 32'h0 : v >> n; e_c = (n > 32) ? 1'b0 : v[n-1]; end
        2: begin
          if (n >= 32) begin e_op = {32{v[31]}}; e_c = v[31]; end
          else begin e_op = 32'($signed(v) >>> n); e_c = v[n-1]; end
        end
        default: begin
          r = n % 32;
          if (r == 0) begin e_op = v; e_c = v[31]; end
          else begin e_op = (v >> r) | (v << (32 - r)); e_c = v[r-1]; end
        end
      endcase
    end
    e_we = fl && (n != 0) && !e_inv;
    if (e_inv) e_op = 0;
  endtask

  task automatic apply(input logic [1:0] f, input logic [15:0] fld, input bit al,
                       input logic [31:0] ar, input bit sf, input logic [31:0] v, input string tag);
    logic [31:0] e_op; logic e_c, e_we, e_inv; logic [3:0] e_src; logic [2:0] e_dst;
    bit bad;
    @(posedge clk);
    fmt = f; field = fld; allow = al; areg = ar; sflags = sf; rval = v;
    @(negedge clk);
    model(e_op, e_c, e_we, e_inv, e_src, e_dst);
    checks++;
    bad = (operand !== e_op) || (carry_we !== e_we) || (invalid !== e_inv)
       || (e_we && carry !== e_c)
       || (!e_inv && fmt != 2'b01 && src_idx !== e_src)
       || (fmt == 2'b10 && dst_idx !== e_dst);
    if (bad) begin
      errors++;
      $display("FAIL %s: actual op=%h c=%b we=%b inv=%b src=%h dst=%h expected op=%h c=%b we=%b inv=%b src=%h dst=%h",
               tag, operand, carry, carry_we, invalid, src_idx, dst_idx,
               e_op, e_c, e_we, e_inv, e_src, e_dst);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    fmt = 0; field = 0; allow = 0; areg = 0; sflags = 0; rval = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(2'b00, 16'h0, 0, 0, 0, 32'h0, "R7 idle");
    // R1 each shift kind
    for (int k = 0; k < 4; k++) apply(2'b00, mk_reg(4, k, 0, 3), 0, 0, 1, 32'h8765_4321, "R1");
    // R2 source and destination indices
    apply(2'b00, mk_reg(1, 0, 0, 10), 0, 0, 1, 32'h1, "R2");
    apply(2'b10, mk_half(1, 2, 6, 5), 0, 0, 0, 32'hF0, "R2");
    // R3 amount source
    apply(2'b00, mk_reg(9, 1, 1, 0), 1, 32'hFFFF_FF03, 1, 32'hFF00_0000, "R3");
    apply(2'b00, mk_reg(9, 1, 1, 0), 0, 32'hFFFF_FF03, 1, 32'hFF00_0000, "R3");
    apply(2'b00, mk_reg(9, 1, 0, 0), 1, 32'h3, 1, 32'hFF00_0000, "R3");
    // R4 left carry
    apply(2'b00, mk_reg(1, 0, 0, 0), 0, 0, 1, 32'h8000_0000, "R4");
    apply(2'b00, mk_reg(31, 0, 0, 0), 0, 0, 1, 32'h0000_0002, "R4");
    // R5 right carries
    apply(2'b00, mk_reg(1, 1, 0, 0), 0, 0, 1, 32'h0000_0001, "R5");
    apply(2'b00, mk_reg(4, 2, 0, 0), 0, 0, 1, 32'h8000_0008, "R5");
    apply(2'b00, mk_reg(8, 3, 0, 0), 0, 0, 1, 32'h0000_0180, "R5");
    // R6 no flag request
    apply(2'b00, mk_reg(1, 0, 0, 0), 0, 0, 0, 32'h8000_0001, "R6");
    // R7 zero amount
    for (int k = 0; k < 4; k++) apply(2'b00, mk_reg(0, k, 0, 0), 0, 0, 1, 32'hDEAD_BEEF, "R7");
    apply(2'b00, mk_reg(0, 0, 1, 0), 1, 32'h0000_0100, 1, 32'hDEAD_BEEF, "R7");
    // R8 large register amounts
    for (int k = 0; k < 4; k++) begin
      apply(2'b00, mk_reg(0, k, 1, 0), 1, 32'd32, 1, 32'h8000_0001, "R8");
      apply(2'b00, mk_reg(0, k, 1, 0), 1, 32'd33, 1, 32'h8000_0001, "R8");
      apply(2'b00, mk_reg(0, k, 1, 0), 1, 32'd64, 1, 32'h8000_0001, "R8");
      apply(2'b00, mk_reg(0, k, 1, 0), 1, 32'd200, 1, 32'h7000_0001, "R8");
    end
    // R9 rotated immediate
    apply(2'b01, 16'h01FF, 0, 0, 1, 32'h0, "R9");
    apply(2'b01, 16'h00AB, 0, 0, 1, 32'h0, "R9");
    apply(2'b01, 16'h0F81, 1, 32'h5, 1, 32'hFFFF_FFFF, "R9");
    // R10 compact form
    for (int k = 0; k < 3; k++) apply(2'b10, mk_half(k, 5, 1, 2), 0, 0, 0, 32'h8000_0030, "R10");
    apply(2'b10, mk_half(0, 0, 1, 2), 0, 0, 1, 32'h8000_0030, "R10");
    // R11 invalid encodings
    apply(2'b10, mk_half(3, 5, 1, 2), 0, 0, 1, 32'h1234_5678, "R11");
    apply(2'b11, 16'hFFFF, 1, 32'h4, 1, 32'h1234_5678, "R11");
    // mixed patterns across R1 R3 R4 R5 R8 R9 R10
    for (int i = 0; i < 2000; i++)
      apply(2'($urandom), 16'($urandom), 1'($urandom), ($urandom % 4 == 0) ? $urandom : $urandom % 70,
            1'($urandom), $urandom, "R4 R5 mixed");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule